// File: doc/BRIEF.md
# Serial Avionics Word Receiver

This block takes a two-wire digital image of a return-to-zero avionics data bus and turns it into qualified 32-bit words. One wire pulses for each transmitted 1 and the other pulses for each transmitted 0. Both wires are asynchronous to the block clock. The clock is nominally 1 MHz and may drift by up to ten percent. Each wire passes through a two-flop synchroniser and then a clock-counted pulse filter. An accepted pulse on either wire shifts one bit into a 32-bit shift register.

A word ends when both filtered wires stay quiet for about two bit periods. A rate-select input sets the length of that quiet time: 20 clocks for the 100 kbit/s rate and 160 clocks for the 12 to 14.5 kbit/s rate. At the end of each word the block judges the word on two counts:
- length, from a bit counter that saturates at 33;
- parity, from a flop that toggles on every 1 received.

It then raises a one-cycle end-of-word pulse. Alongside that pulse it raises either a good-word strobe or the transmission-fault flag. Label matching, latching and host access sit in other blocks that watch these outputs.

The framing state machine has three states:
- `ST_WAIT` idles until the first accepted bit.
- `ST_SHIFT` collects bits while a gap timer runs over quiet cycles.
- `ST_JUDGE` issues the verdict and clears the counters.

It has three transitions:
- first bit: `ST_WAIT` to `ST_SHIFT`.
- gap timeout: `ST_SHIFT` to `ST_JUDGE`.
- verdict done: `ST_JUDGE` to `ST_WAIT`.

Top module: `a429_word_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `eow_pulse`, `good_word` and `xmit_fault` are 0. They stay 0 until a word has been received.
- R2: An accepted pulse on `line_one` shifts in a 1 and an accepted pulse on `line_zero` shifts in a 0. After 32 bits, the first bit received is at `word_q[0]` and the 32nd is at `word_q[31]`.
- R3: A pulse of 2 clock cycles or shorter on either line is ignored. A pulse of 3 cycles or longer is accepted as a bit.
- R4: End of word is declared only after both filtered lines have stayed low for 20 cycles (`rate_low`=0) or 160 cycles (`rate_low`=1). Relative to the cycle the input line falls, `eow_pulse` rises 6 cycles after that limit, and it lasts exactly one cycle.
- R5: `good_word` pulses together with `eow_pulse` only when exactly 32 bits arrived and the number of 1s among them is odd.
- R6: `xmit_fault` is set at end of word when the length or the parity check fails. It holds until the next end of word, where a good word clears it. It is never high during a `good_word` pulse.
- R7: The bit counter saturates at 33, so a burst of 96 bits with odd parity ends in a fault, not a good word.
- R8: With no accepted bit since the last verdict or since reset, no end of word is declared, however long the lines stay quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock, nominally 1 MHz |
| rst_n | input | 1 | Active-low reset |
| rate_low | input | 1 | 0: high bit rate, 1: low bit rate |
| line_one | input | 1 | Asynchronous pulse line for transmitted 1s |
| line_zero | input | 1 | Asynchronous pulse line for transmitted 0s |
| word_q | output | 32 | Shift register contents, first bit received at index 0 |
| eow_pulse | output | 1 | One-cycle end-of-word pulse |
| good_word | output | 1 | One-cycle strobe with `eow_pulse` for a qualified word |
| xmit_fault | output | 1 | Length or parity failure of the latest word |

## Verification
The bench sends two distinct odd-parity words at the fast rate and one at the slow rate. This separates correct bit order and value recovery from a swapped or reversed shift, and a wrong gap limit from a right one. Intra-word nulls are longer than the fast limit at the slow rate, so a rate select that is ignored breaks the word apart. Single-bit-flip parity errors and word lengths of 31, 33 and 96 bits separate the parity check from the length check. The 96-bit case is the one that shows whether the counter saturates or wraps. Pulses of 1 and 2 cycles against pulses of 3 cycles pin the filter threshold. Quiet lines after reset show that no spurious verdict is issued.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_JUDGE = 2'd2
    } rx_state_e;

    localparam int WORD_BITS_DEF = 32;
    localparam int FILT_LEN_DEF  = 3;
    localparam int GAP_FAST_DEF  = 20;
    localparam int GAP_SLOW_DEF  = 160;

endpackage

// File: rtl/a429_line_filter.sv
module a429_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_filt,
    output logic line_rise
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_cnt;
    logic          filt_q;
    logic          filt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '0;
            run_cnt <= '0;
            filt_q  <= 1'b0;
            filt_d  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], line_async};
            filt_d <= filt_q;
            if (sync_q[1] != filt_q) begin
                if (run_cnt == CW'(FILT_LEN - 1)) begin
                    filt_q  <= sync_q[1];
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end

    assign line_filt = filt_q;
    assign line_rise = filt_q & ~filt_d;

    AST_RISE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filt_q) |-> ($past(sync_q[1]) && $past(sync_q[1], 2))); // R3

endmodule

// File: rtl/a429_word_qual.sv
module a429_word_qual #(
    parameter int WORD_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_stb,
    input  logic                 bit_val,
    input  logic                 clr,
    output logic [WORD_BITS-1:0] word,
    output logic                 word_ok
);
    localparam int CNT_MAX = WORD_BITS + 1;
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic [WORD_BITS-1:0] shift_q;
    logic [CW-1:0]        bit_cnt;
    logic                 par_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            bit_cnt <= '0;
            par_q   <= 1'b0;
        end else if (clr) begin
            bit_cnt <= '0;
            par_q   <= 1'b0;
        end else if (bit_stb) begin
            shift_q <= {bit_val, shift_q[WORD_BITS-1:1]};
            if (bit_cnt != CW'(CNT_MAX))
                bit_cnt <= bit_cnt + 1'b1;
            if (bit_val)
                par_q <= ~par_q;
        end
    end

    assign word    = shift_q;
    assign word_ok = (bit_cnt == CW'(WORD_BITS)) && par_q;

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CW'(CNT_MAX)); // R7

    AST_CNT_HOLDS_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == CW'(CNT_MAX) && bit_stb && !clr) |=> (bit_cnt == CW'(CNT_MAX))); // R7

endmodule

// File: rtl/a429_frame_fsm.sv
module a429_frame_fsm
    import a429_rx_pkg::*;
#(
    parameter int GAP_FAST = 20,
    parameter int GAP_SLOW = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_low,
    input  logic one_f,
    input  logic zero_f,
    input  logic bit_stb,
    input  logic word_ok,
    output logic clr,
    output logic eow,
    output logic good,
    output logic fault
);
    localparam int GMAX = (GAP_SLOW > GAP_FAST) ? GAP_SLOW : GAP_FAST;
    localparam int GW   = $clog2(GMAX + 1);

    rx_state_e     state_q, state_n;
    logic [GW-1:0] gap_cnt;
    logic [GW-1:0] gap_lim;
    logic          quiet;
    logic          gap_done;

    assign quiet    = ~one_f & ~zero_f;
    assign gap_lim  = rate_low ? GW'(GAP_SLOW) : GW'(GAP_FAST);
    assign gap_done = quiet && (gap_cnt == gap_lim - 1'b1);
    assign clr      = (state_q == ST_JUDGE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap_cnt <= '0;
        else if (state_q == ST_SHIFT && quiet)
            gap_cnt <= gap_cnt + 1'b1;
        else
            gap_cnt <= '0;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_WAIT:  if (bit_stb)  state_n = ST_SHIFT;
            ST_SHIFT: if (gap_done) state_n = ST_JUDGE;
            ST_JUDGE:               state_n = ST_WAIT;
            default:                state_n = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_WAIT;
        else
            state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eow   <= 1'b0;
            good  <= 1'b0;
            fault <= 1'b0;
        end else begin
            eow  <= (state_q == ST_JUDGE);
            good <= (state_q == ST_JUDGE) && word_ok;
            if (state_q == ST_JUDGE)
                fault <= ~word_ok;
        end
    end

    AST_EOW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eow |=> !eow); // R4

    AST_EOW_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eow) |-> ($past(quiet, 2))); // R4

    AST_GOOD_WITH_EOW: assert property (@(posedge clk) disable iff (!rst_n)
        good |-> eow); // R5

    AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        good |-> !fault); // R6

endmodule

// File: rtl/a429_word_rx.sv
module a429_word_rx
    import a429_rx_pkg::*;
#(
    parameter int WORD_BITS = WORD_BITS_DEF,
    parameter int FILT_LEN  = FILT_LEN_DEF,
    parameter int GAP_FAST  = GAP_FAST_DEF,
    parameter int GAP_SLOW  = GAP_SLOW_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rate_low,
    input  logic                 line_one,
    input  logic                 line_zero,
    output logic [WORD_BITS-1:0] word_q,
    output logic                 eow_pulse,
    output logic                 good_word,
    output logic                 xmit_fault
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_l;
    logic [NLINES-1:0] filt_l;
    logic [NLINES-1:0] rise_l;
    logic              bit_stb;
    logic              bit_val;
    logic              clr;
    logic              word_ok;

    assign raw_l = {line_one, line_zero};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        a429_line_filter #(.FILT_LEN(FILT_LEN)) i_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_async(raw_l[g]),
            .line_filt (filt_l[g]),
            .line_rise (rise_l[g])
        );
    end

    assign bit_stb = |rise_l;
    assign bit_val = rise_l[1];

    a429_word_qual #(.WORD_BITS(WORD_BITS)) i_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_stb(bit_stb),
        .bit_val(bit_val),
        .clr    (clr),
        .word   (word_q),
        .word_ok(word_ok)
    );

    a429_frame_fsm #(.GAP_FAST(GAP_FAST), .GAP_SLOW(GAP_SLOW)) i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate_low(rate_low),
        .one_f   (filt_l[1]),
        .zero_f  (filt_l[0]),
        .bit_stb (bit_stb),
        .word_ok (word_ok),
        .clr     (clr),
        .eow     (eow_pulse),
        .good    (good_word),
        .fault   (xmit_fault)
    );

endmodule

// File: tb/test_a429_word_rx.sv
module test_a429_word_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_low = 1'b0;
    logic        line_one = 1'b0;
    logic        line_zero = 1'b0;
    logic [31:0] word_q;
    logic        eow_pulse, good_word, xmit_fault;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    a429_word_rx i_a429_word_rx (
        .clk(clk), .rst_n(rst_n), .rate_low(rate_low),
        .line_one(line_one), .line_zero(line_zero),
        .word_q(word_q), .eow_pulse(eow_pulse),
        .good_word(good_word), .xmit_fault(xmit_fault)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] make_word(input logic [30:0] p);
        return {~^p, p};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit v, input int hi, input int lo);
        if (v) line_one = 1'b1; else line_zero = 1'b1;
        repeat (hi) @(negedge clk);
        line_one = 1'b0; line_zero = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    // sends n bits of w (bit i of w goes out i-th), last bit has no null after it
    task automatic send_bits(input logic [127:0] w, input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++)
            send_bit(w[i], hi, (i == n - 1) ? 0 : lo);
    endtask

    task automatic wait_eow(input int maxc, output int k, output bit seen,
                            output bit g, output bit f, output logic [31:0] w);
        seen = 1'b0; k = 0; g = 1'b0; f = 1'b0; w = '0;
        for (int i = 1; i <= maxc; i++) begin
            @(negedge clk);
            if (eow_pulse) begin
                seen = 1'b1; k = i; g = good_word; f = xmit_fault; w = word_q;
                break;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(5);
        check(!eow_pulse && !good_word && !xmit_fault, "R1 outputs in reset",
              {eow_pulse, good_word, xmit_fault}, 0);
        rst_n = 1'b1;
        idle(2);
        check(!eow_pulse && !good_word && !xmit_fault, "R1 outputs after release",
              {eow_pulse, good_word, xmit_fault}, 0);
    endtask

    task automatic t_quiet();
        int n_eow = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (eow_pulse) n_eow++;
        end
        check(n_eow == 0, "R8 no verdict on quiet lines", n_eow, 0);
    endtask

    task automatic t_good(input logic [30:0] p, input bit slow, input string tag);
        logic [31:0] w, got;
        int k, lim, hi, lo;
        bit seen, g, f;
        w = make_word(p);
        rate_low = slow;
        lim = slow ? 160 : 20;
        hi  = slow ? 37 : 5;
        lo  = slow ? 38 : 5;
        send_bits({96'b0, w}, 32, hi, lo);
        wait_eow(lim + 40, k, seen, g, f, got);
        check(seen && (k >= lim + 3) && (k <= lim + 9), {"R4 eow timing ", tag}, k, lim + 6);
        check(g && !f, {"R5 good verdict ", tag}, {g, f}, 2);
        check(got == w, {"R2 word contents ", tag}, got, w);
        @(negedge clk);
        check(!eow_pulse && !good_word, {"R4 single-cycle eow ", tag}, {eow_pulse, good_word}, 0);
        idle(slow ? 320 : 40);
    endtask

    task automatic t_bad(input logic [127:0] bits, input int n, input string tag);
        logic [31:0] got;
        int k;
        bit seen, g, f;
        rate_low = 1'b0;
        send_bits(bits, n, 5, 5);
        wait_eow(60, k, seen, g, f, got);
        check(seen && !g && f, {tag, " fault verdict"}, {seen, g, f}, 5);
        idle(40);
        check(xmit_fault, {"R6 fault held ", tag}, xmit_fault, 1);
    endtask

    task automatic t_glitch();
        int n_eow = 0;
        rate_low = 1'b0;
        send_bit(1'b1, 2, 10);
        send_bit(1'b0, 1, 10);
        send_bit(1'b0, 2, 10);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (eow_pulse) n_eow++;
        end
        check(n_eow == 0, "R3 short pulses ignored", n_eow, 0);
    endtask

    task automatic t_min_pulse();
        logic [31:0] w, got;
        int k;
        bit seen, g, f;
        rate_low = 1'b0;
        w = make_word(31'h2C0F_5A33);
        send_bits({96'b0, w}, 32, 3, 4);
        wait_eow(60, k, seen, g, f, got);
        check(seen && g && got == w, "R3 three-cycle pulses accepted", got, w);
        idle(40);
    endtask

    initial begin
        logic [31:0] wb;
        t_reset();
        t_quiet();
        t_good(31'h1234_5678, 1'b0, "fast A");
        t_good(31'h6D00_00F1, 1'b0, "fast B");
        wb = make_word(31'h0ACE_1234);
        t_bad({96'b0, wb ^ 32'h8000_0000}, 32, "R5 parity error");
        t_good(31'h0000_0001, 1'b0, "R6 fault cleared");
        check(!xmit_fault, "R6 fault cleared by good word", xmit_fault, 0);
        t_bad({97'b0, 31'h0000_0001}, 31, "R5 short word");
        t_bad({95'b0, 33'h1}, 33, "R5 long word");
        t_bad({127'b0, 1'b1}, 96, "R7 saturating count");
        t_glitch();
        t_min_pulse();
        t_good(31'h5555_0F0F, 1'b1, "slow");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule